// File: doc/BRIEF.md
# Dual-Channel Serial DAC Code Register Front End

This block is the digital input stage of a two-channel serial digital-to-analog converter. A host shifts a code into a serial shift register, one bit per rising edge of a slow serial clock, while its active-low select is held low. Two active-low, level-sensitive load strobes then copy the shift register into the two channel code registers. Each code register feeds one converter channel.

An asynchronous active-low force pin drives both code registers to zero or to midscale, depending on a separate midscale-select pin. The value stays in place after the force pin is released. A shutdown pin only raises a status flag: the registers keep their contents, and shifting and loading still work while it is asserted. Every pin is brought into a fast system clock domain through two-flop synchronizers, and serial clock edges are detected in that domain. The system clock must run at least four times faster than the serial clock.

The block also reports two events. A sticky protocol-error flag is set when a serial bit is shifted while a load strobe is low, and a dedicated clear input resets it. A one-cycle update pulse per channel marks every change of that channel's code.

Top module: `dual_dac_frontend`

## Requirements
- R1: The shift register takes one bit only on a rising serial-clock edge seen while the select pin is low. Serial-clock edges seen while select is high leave it unchanged.
- R2: Bits enter MSB first by shifting toward the MSB. When more than CODE_W bits are shifted in one frame, only the last CODE_W bits received are kept.
- R3: While a load strobe is low and force is high, that channel's code follows the shift register. After the strobe returns high, the code holds its last value.
- R4: The load strobes work whether the select pin is high or low.
- R5: Driving both load strobes low together puts the same shift-register value into both channels.
- R6: While force is low, both codes are midscale (only bit CODE_W-1 set) if midscale-select is high, or zero if it is low. This holds whatever the load strobes do. After force rises with the strobes high, the value stays. Force never changes the shift register.
- R7: The shutdown-active output is high while the shutdown pin is low. Shutdown changes no register, and shifting and loading still work during it.
- R8: The protocol-error flag is set by a shifting serial-clock edge while either load strobe is low. It stays set until the clear input is high for one system clock.
- R9: Each channel's update output is high for exactly one system clock in the first cycle the code holds a new value, and it is never high otherwise.
- R10: After system reset both codes are zero and all flags and pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| sel_n | input | 1 | Serial select, active low |
| load_a_n | input | 1 | Channel A load strobe, level sensitive, active low |
| load_b_n | input | 1 | Channel B load strobe, level sensitive, active low |
| force_n | input | 1 | Preset force of both codes, active low |
| mid_sel | input | 1 | Preset value: 1 gives midscale, 0 gives zero |
| sleep_n | input | 1 | Shutdown request, active low |
| err_clr | input | 1 | Clears the protocol-error flag (system-clock domain) |
| code_a | output | CODE_W | Channel A code register |
| code_b | output | CODE_W | Channel B code register |
| upd_a | output | 1 | One-cycle pulse when code_a changes |
| upd_b | output | 1 | One-cycle pulse when code_b changes |
| sleep_active | output | 1 | Shutdown is asserted |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The hardest state to reach from the pins is a serial bit arriving while a load strobe is already low. In that state the code tracks the shift register bit by bit, each step raises an update pulse, and the error flag must latch. The stimulus drops a strobe before a frame begins, shifts a whole random frame through the transparent register, and then compares the code, the counted update pulses and the error flag with a bench model. Frames that are too long, frames shifted with select high, and force pulses applied while a strobe is low are mixed into the random sequence.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    // Source that drives a channel code register in a given cycle
    typedef enum logic [1:0] {
        CH_HOLD  = 2'd0,
        CH_LOAD  = 2'd1,
        CH_FORCE = 2'd2
    } ch_mode_e;

    // Position of each pin in the synchronizer bundle
    localparam int PIN_SCLK  = 0;
    localparam int PIN_DIN   = 1;
    localparam int PIN_SEL   = 2;
    localparam int PIN_LDA   = 3;
    localparam int PIN_LDB   = 4;
    localparam int PIN_FORCE = 5;
    localparam int PIN_MID   = 6;
    localparam int PIN_SLEEP = 7;
    localparam int PIN_COUNT = 8;

    // Idle level of each pin, used as the synchronizer reset value
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = 8'b1011_1100;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int            WIDTH   = 8,
    parameter int            STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              sel_n_s,
    input  logic              any_load_s,
    input  logic              err_clr,
    output logic [CODE_W-1:0] sr_o,
    output logic              err_o
);

    typedef struct packed {
        logic [CODE_W-1:0] sr;
        logic              sclk_prev;
        logic              err;
    } shf_state_t;

    shf_state_t st_q, st_d;
    logic       sclk_rise;
    logic       shift_en;

    always_comb begin
        sclk_rise = sclk_s & ~st_q.sclk_prev;
        shift_en  = sclk_rise & ~sel_n_s;

        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        if (shift_en) begin
            // bits older than CODE_W fall off the top
            st_d.sr = {st_q.sr[CODE_W-2:0], din_s};
        end
        if (err_clr) begin
            st_d.err = 1'b0;
        end
        if (shift_en && any_load_s) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o  = st_q.sr;
    assign err_o = st_q.err;

    AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_s && !st_q.sclk_prev && !sel_n_s) |=> $stable(st_q.sr)); // R1
    AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !st_q.sclk_prev && !sel_n_s) |=> (st_q.sr[0] == $past(din_s))); // R2
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !st_q.sclk_prev && !sel_n_s && any_load_s) |=> st_q.err); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !err_clr) |=> st_q.err); // R8

endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n_s,
    input  logic              force_n_s,
    input  logic              mid_s,
    input  logic [CODE_W-1:0] sr_i,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o
);

    localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              upd;
    } ch_state_t;

    ch_state_t         st_q, st_d;
    ch_mode_e          mode;
    logic [CODE_W-1:0] preset;

    always_comb begin
        preset = mid_s ? MIDSCALE : '0;
        if (!force_n_s) begin
            mode = CH_FORCE;
        end else if (!load_n_s) begin
            mode = CH_LOAD;
        end else begin
            mode = CH_HOLD;
        end

        st_d = st_q;
        unique case (mode)
            CH_FORCE: st_d.code = preset;
            CH_LOAD:  st_d.code = sr_i;
            default:  st_d.code = st_q.code;
        endcase
        st_d.upd = (st_d.code != st_q.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign upd_o  = st_q.upd;

    AST_FOLLOW_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n_s && force_n_s) |=> (st_q.code == $past(sr_i))); // R3
    AST_HOLD_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && force_n_s) |=> $stable(st_q.code)); // R3
    AST_FORCE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_n_s && mid_s) |=> (st_q.code == MIDSCALE)); // R6
    AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_n_s && !mid_s) |=> (st_q.code == '0)); // R6
    AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code != $past(st_q.code)) |-> st_q.upd); // R9
    AST_UPD_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |-> (st_q.code != $past(st_q.code))); // R9

endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
    import dacfe_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              sel_n,
    input  logic              load_a_n,
    input  logic              load_b_n,
    input  logic              force_n,
    input  logic              mid_sel,
    input  logic              sleep_n,
    input  logic              err_clr,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              upd_a,
    output logic              upd_b,
    output logic              sleep_active,
    output logic              proto_err
);

    localparam int N_CH = 2;

    logic [PIN_COUNT-1:0] pins_raw;
    logic [PIN_COUNT-1:0] pins_s;
    logic [CODE_W-1:0]    sr;
    logic [N_CH-1:0]      load_n_s;
    logic [CODE_W-1:0]    code_arr [N_CH];
    logic [N_CH-1:0]      upd_arr;

    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_SCLK]  = ser_clk;
        pins_raw[PIN_DIN]   = ser_din;
        pins_raw[PIN_SEL]   = sel_n;
        pins_raw[PIN_LDA]   = load_a_n;
        pins_raw[PIN_LDB]   = load_b_n;
        pins_raw[PIN_FORCE] = force_n;
        pins_raw[PIN_MID]   = mid_sel;
        pins_raw[PIN_SLEEP] = sleep_n;
    end

    dacfe_sync #(
        .WIDTH   (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    assign load_n_s = {pins_s[PIN_LDB], pins_s[PIN_LDA]};

    dacfe_shifter #(
        .CODE_W (CODE_W)
    ) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[PIN_SCLK]),
        .din_s      (pins_s[PIN_DIN]),
        .sel_n_s    (pins_s[PIN_SEL]),
        .any_load_s (~&load_n_s),
        .err_clr    (err_clr),
        .sr_o       (sr),
        .err_o      (proto_err)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        dacfe_chan #(
            .CODE_W (CODE_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_n_s  (load_n_s[c]),
            .force_n_s (pins_s[PIN_FORCE]),
            .mid_s     (pins_s[PIN_MID]),
            .sr_i      (sr),
            .code_o    (code_arr[c]),
            .upd_o     (upd_arr[c])
        );
    end

    assign code_a       = code_arr[0];
    assign code_b       = code_arr[1];
    assign upd_a        = upd_arr[0];
    assign upd_b        = upd_arr[1];
    assign sleep_active = ~pins_s[PIN_SLEEP];

    AST_BOTH_LOADS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s == 2'b00 && pins_s[PIN_FORCE]) |=> (code_a == code_b)); // R5
    AST_FORCE_KEEPS_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_s[PIN_FORCE] && pins_s[PIN_SEL]) |=> $stable(sr)); // R6

endmodule

// File: tb/dual_dac_frontend_bench.sv
module dual_dac_frontend_bench;

    localparam int W = 12;
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b0, ser_din = 1'b0, sel_n = 1'b1;
    logic         load_a_n = 1'b1, load_b_n = 1'b1;
    logic         force_n = 1'b1, mid_sel = 1'b0, sleep_n = 1'b1, err_clr = 1'b0;
    logic [W-1:0] code_a, code_b;
    logic         upd_a, upd_b, sleep_active, proto_err;

    int checks = 0, errors = 0;
    int pulses_a = 0, pulses_b = 0, exp_ua = 0, exp_ub = 0;
    bit done = 1'b0;
    logic [W-1:0] msr = '0, ma = '0, mb = '0;
    logic         merr = 1'b0;

    always #2 clk = ~clk;

    dual_dac_frontend #(.CODE_W(W)) u_dual_dac_frontend (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .sel_n(sel_n), .load_a_n(load_a_n), .load_b_n(load_b_n),
        .force_n(force_n), .mid_sel(mid_sel), .sleep_n(sleep_n),
        .err_clr(err_clr), .code_a(code_a), .code_b(code_b),
        .upd_a(upd_a), .upd_b(upd_b), .sleep_active(sleep_active),
        .proto_err(proto_err)
    );

    always @(negedge clk) begin
        if (rst_n && upd_a) pulses_a++;
        if (rst_n && upd_b) pulses_b++;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic void set_a(input logic [W-1:0] v);
        if (v != ma) exp_ua++;
        ma = v;
    endfunction

    function automatic void set_b(input logic [W-1:0] v);
        if (v != mb) exp_ub++;
        mb = v;
    endfunction

    function automatic void model_shift(input logic b);
        msr = {msr[W-2:0], b};
        if (!load_a_n || !load_b_n) merr = 1'b1;
        if (!load_a_n) set_a(msr);
        if (!load_b_n) set_b(msr);
    endfunction

    task automatic send(input logic [31:0] data, input int n, input bit en);
        sel_n = !en;
        wait_cyc(3);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = data[i];
            wait_cyc(3);
            ser_clk = 1'b1;
            if (en) model_shift(data[i]);
            wait_cyc(6);
            ser_clk = 1'b0;
            wait_cyc(3);
        end
        sel_n = 1'b1;
        wait_cyc(8);
    endtask

    task automatic strobe(input bit a, input bit b);
        load_a_n = !a;
        load_b_n = !b;
        if (a) set_a(msr);
        if (b) set_b(msr);
        wait_cyc(8);
        load_a_n = 1'b1;
        load_b_n = 1'b1;
        wait_cyc(8);
    endtask

    task automatic check_codes(input string req);
        check(req, 16'(code_a), 16'(ma));
        check(req, 16'(code_b), 16'(mb));
        check({req, " upd_a count (R9)"}, 16'(pulses_a), 16'(exp_ua));
        check({req, " upd_b count (R9)"}, 16'(pulses_b), 16'(exp_ub));
    endtask

    task automatic apply_force(input bit mid, input bit with_load);
        mid_sel = mid;
        force_n = 1'b0;
        set_a(mid ? MID : '0);
        set_b(mid ? MID : '0);
        wait_cyc(8);
        if (with_load) begin
            load_a_n = 1'b0;
            wait_cyc(8);
            check("R6 force over load", 16'(code_a), 16'(ma));
            load_a_n = 1'b1;
            wait_cyc(4);
        end
        force_n = 1'b1;
        wait_cyc(8);
        check_codes("R6 force held");
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);
        // R10 reset state
        check("R10 code_a", 16'(code_a), 16'h0);
        check("R10 code_b", 16'(code_b), 16'h0);
        check("R10 flags", {12'h0, upd_a, upd_b, sleep_active, proto_err}, 16'h0);

        // R2 exact frame, R3 load A only with select high (R4)
        send(32'hA5C, W, 1'b1);
        strobe(1'b1, 1'b0);
        check_codes("R2/R3/R4 load A");
        // R2 long frame keeps the last W bits
        send(32'hFAB3C, 20, 1'b1);
        strobe(1'b0, 1'b1);
        check_codes("R2 long frame");
        // R1 frame with select high is ignored
        send(32'h123, W, 1'b0);
        strobe(1'b1, 1'b1);
        check_codes("R1/R5 select high then both");
        // R6 midscale, zero, force while load low, shift register kept
        apply_force(1'b1, 1'b0);
        apply_force(1'b0, 1'b1);
        strobe(1'b1, 1'b0);
        check_codes("R6 shift register kept");
        // R7 shutdown
        sleep_n = 1'b0;
        wait_cyc(6);
        check("R7 sleep flag", 16'(sleep_active), 16'h1);
        check_codes("R7 registers kept");
        send(32'h3E7, W, 1'b1);
        strobe(1'b1, 1'b1);
        check_codes("R7 load in shutdown");
        sleep_n = 1'b1;
        wait_cyc(6);
        check("R7 sleep flag off", 16'(sleep_active), 16'h0);
        // R8 shifting while a strobe is low
        check("R8 flag clear before", 16'(proto_err), 16'h0);
        load_b_n = 1'b0;
        set_b(msr);
        send(32'h5A6, W, 1'b1);
        load_b_n = 1'b1;
        wait_cyc(8);
        check_codes("R3/R8 transparent shift");
        check("R8 flag set", 16'(proto_err), {15'h0, merr});
        wait_cyc(20);
        check("R8 sticky", 16'(proto_err), 16'h1);
        err_clr = 1'b1;
        wait_cyc(1);
        err_clr = 1'b0;
        merr = 1'b0;
        wait_cyc(2);
        check("R8 cleared", 16'(proto_err), 16'h0);

        // constrained random frames
        for (int it = 0; it < 60; it++) begin
            int n;
            bit en;
            int ld;
            n  = W + int'($urandom % 5);
            en = ($urandom % 4) != 0;
            ld = int'($urandom % 4);
            send($urandom, n, en);
            strobe(ld[0], ld[1]);
            check_codes("R1/R2/R3/R5 random");
            if (it % 12 == 5) apply_force($urandom % 2 == 1, $urandom % 2 == 1);
        end
        check("R8 no false error", 16'(proto_err), 16'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule